// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block is the core-side controller that steps one coprocessor instruction through its execute stage. The pipeline tells it when a coprocessor instruction is about to enter execute and whether its condition codes passed. The block then reads the coprocessor's two-bit handshake replies and decides the outcome. The instruction may trap as undefined, wait while the pipeline stalls, take further execute cycles, or complete. An interrupt can abandon the wait, and the block can cancel the instruction late when the instruction before it aborted.

There are two handshake buses. One answers for an instruction that is arriving (`hs_dec`). The other answers for an instruction that is already executing and needs another cycle (`hs_exe`). Both are captured on the falling clock edge. The state machine advances on the rising edge, and every output is decoded from the current state alone.

The states are:
- IDLE: nothing in flight.
- BUSY: busy-wait.
- STEP: an execute cycle after GO.
- FINAL: the execute cycle after LAST.
- UNDEF: trap pulse.
- RETIRE: the instruction failed its condition codes.
- CANCEL: late-cancel pulse.
- DONE: completion pulse.

The transitions are:
- IDLE goes to RETIRE when an issued instruction fails its condition codes.
- IDLE goes to UNDEF, BUSY, STEP or FINAL when the instruction passes, following `hs_dec`.
- BUSY and STEP follow `hs_exe` to UNDEF, BUSY, STEP or FINAL.
- BUSY goes to IDLE on an interrupt.
- FINAL goes to DONE.
- BUSY, STEP and FINAL go to CANCEL when a prior abort is seen in the first execute cycle.
- UNDEF, RETIRE, CANCEL and DONE return to IDLE.

Top module: `cop_hs_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are low.
- R2: The handshake codes are WAIT=2'b00, GO=2'b01, ABSENT=2'b10 and LAST=2'b11. An arriving instruction is decided on `hs_dec`, and an executing one on `hs_exe`. Each bus is taken at the falling edge that comes before the deciding rising edge, so a later change in the same cycle has no effect.
- R3: ABSENT on first evaluation, or on `hs_exe` during execute, gives exactly one cycle of `undef_trap` in the next cycle, with `cp_pass` low.
- R4: WAIT puts the block into a busy-wait. It holds `cp_pass` and `pipe_stall` high on every cycle for as long as `hs_exe` reads WAIT.
- R5: GO gives an execute cycle with `cp_pass` high and `pipe_stall` low, and `hs_exe` keeps being evaluated.
- R6: LAST gives one execute cycle with `cp_pass` high. A one-cycle `instr_done` pulse with `cp_pass` low follows it.
- R7: `irq_req` seen at a rising edge during a busy-wait ends the wait. In the next cycle `cp_pass` and `pipe_stall` are low, and no trap or done pulse follows.
- R8: `prior_abort` high at the rising edge that ends the first execute cycle gives a one-cycle `cp_late_cancel` in the next cycle, with `cp_pass` low and no done pulse. `prior_abort` in any other cycle has no effect.
- R9: An issued instruction with `cond_pass` low is retired. The next cycle shows `instr_done` high and `cp_pass` low, with no trap, whatever `hs_dec` reads.
- R10: `issue_vld` is accepted only in IDLE. While an instruction is in flight, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | A coprocessor instruction enters execute in the next cycle |
| cond_pass | input | 1 | The issued instruction passed its condition codes |
| irq_req | input | 1 | Interrupt request |
| prior_abort | input | 1 | The preceding instruction caused a data abort |
| hs_dec | input | 2 | Coprocessor reply for an arriving instruction |
| hs_exe | input | 2 | Coprocessor reply for an executing instruction |
| cp_pass | output | 1 | The execute-stage coprocessor instruction is live |
| cp_late_cancel | output | 1 | Cancel the instruction because the previous one aborted |
| pipe_stall | output | 1 | Stall the pipeline during a busy-wait |
| undef_trap | output | 1 | Pulse: take the undefined-instruction trap |
| instr_done | output | 1 | Pulse: the instruction completed or retired |

## Verification
The late-cancel slot is the hardest situation to reach. `prior_abort` must be high at exactly the rising edge that closes the first execute cycle, and never at any other edge. The bench therefore issues an instruction and raises the abort only on the following step. It then repeats the abort one cycle later inside a busy-wait, to show that the abort is ignored there. The falling-edge capture is forced by changing `hs_dec` between the falling and the rising edge and checking that the earlier value decided the outcome.

// File: rtl/cop_hs_pkg.sv
package cop_hs_pkg;

    localparam int HS_W = 2;

    typedef enum logic [HS_W-1:0] {
        HS_WAIT   = 2'b00,
        HS_GO     = 2'b01,
        HS_ABSENT = 2'b10,
        HS_LAST   = 2'b11
    } hs_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_STEP,
        ST_FINAL,
        ST_UNDEF,
        ST_RETIRE,
        ST_CANCEL,
        ST_DONE
    } seq_state_e;

    // Map a handshake reply onto the state it leads to.
    function automatic seq_state_e hs_target(input hs_code_e code);
        seq_state_e nxt;
        unique case (code)
            HS_ABSENT: nxt = ST_UNDEF;
            HS_WAIT:   nxt = ST_BUSY;
            HS_GO:     nxt = ST_STEP;
            HS_LAST:   nxt = ST_FINAL;
            default:   nxt = ST_UNDEF;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cop_hs_sampler.sv
module cop_hs_sampler #(
    parameter int W    = 2,
    parameter int NBUS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBUS*W-1:0] bus_i,
    output logic [NBUS*W-1:0] bus_q
);

    // Each handshake bus is captured on the falling clock edge.
    for (genvar g = 0; g < NBUS; g++) begin : g_bus
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bus_q[g*W +: W] <= '0;
            end else begin
                bus_q[g*W +: W] <= bus_i[g*W +: W];
            end
        end
    end

endmodule

// File: rtl/cop_hs_fsm.sv
module cop_hs_fsm
    import cop_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic            cond_pass,
    input  logic            irq_req,
    input  logic            prior_abort,
    input  logic [HS_W-1:0] dec_q,
    input  logic [HS_W-1:0] exe_q,
    output seq_state_e      state
);

    seq_state_e state_nxt;
    logic       first_q;
    logic       first_nxt;
    logic       cancel_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            state   <= state_nxt;
            first_q <= first_nxt;
        end
    end

    // The late-cancel slot only exists in the first execute cycle.
    assign cancel_now = first_q && prior_abort;
    assign first_nxt  = (state == ST_IDLE) && issue_vld && cond_pass;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (issue_vld) begin
                    state_nxt = cond_pass ? hs_target(hs_code_e'(dec_q)) : ST_RETIRE;
                end
            end
            ST_BUSY: begin
                if (cancel_now) begin
                    state_nxt = ST_CANCEL;
                end else if (irq_req) begin
                    state_nxt = ST_IDLE;
                end else begin
                    state_nxt = hs_target(hs_code_e'(exe_q));
                end
            end
            ST_STEP: begin
                state_nxt = cancel_now ? ST_CANCEL : hs_target(hs_code_e'(exe_q));
            end
            ST_FINAL: begin
                state_nxt = cancel_now ? ST_CANCEL : ST_DONE;
            end
            ST_UNDEF,
            ST_RETIRE,
            ST_CANCEL,
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/cop_hs_outdec.sv
module cop_hs_outdec
    import cop_hs_pkg::*;
(
    input  seq_state_e state,
    output logic       cp_pass,
    output logic       cp_late_cancel,
    output logic       pipe_stall,
    output logic       undef_trap,
    output logic       instr_done
);

    always_comb begin
        cp_pass        = 1'b0;
        cp_late_cancel = 1'b0;
        pipe_stall     = 1'b0;
        undef_trap     = 1'b0;
        instr_done     = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_BUSY: begin
                cp_pass    = 1'b1;
                pipe_stall = 1'b1;
            end
            ST_STEP:   cp_pass        = 1'b1;
            ST_FINAL:  cp_pass        = 1'b1;
            ST_UNDEF:  undef_trap     = 1'b1;
            ST_RETIRE: instr_done     = 1'b1;
            ST_CANCEL: cp_late_cancel = 1'b1;
            ST_DONE:   instr_done     = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/cop_hs_seq.sv
module cop_hs_seq
    import cop_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic            cond_pass,
    input  logic            irq_req,
    input  logic            prior_abort,
    input  logic [HS_W-1:0] hs_dec,
    input  logic [HS_W-1:0] hs_exe,
    output logic            cp_pass,
    output logic            cp_late_cancel,
    output logic            pipe_stall,
    output logic            undef_trap,
    output logic            instr_done
);

    localparam int NBUS = 2;

    logic [NBUS*HS_W-1:0] hs_q;
    seq_state_e           state;

    cop_hs_sampler #(
        .W    (HS_W),
        .NBUS (NBUS)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .bus_i ({hs_exe, hs_dec}),
        .bus_q (hs_q)
    );

    cop_hs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_vld   (issue_vld),
        .cond_pass   (cond_pass),
        .irq_req     (irq_req),
        .prior_abort (prior_abort),
        .dec_q       (hs_q[HS_W-1:0]),
        .exe_q       (hs_q[2*HS_W-1:HS_W]),
        .state       (state)
    );

    cop_hs_outdec u_outdec (
        .state          (state),
        .cp_pass        (cp_pass),
        .cp_late_cancel (cp_late_cancel),
        .pipe_stall     (pipe_stall),
        .undef_trap     (undef_trap),
        .instr_done     (instr_done)
    );

endmodule

// File: rtl/cop_hs_seq_chk.sv
module cop_hs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_req,
    input logic prior_abort,
    input logic cp_pass,
    input logic cp_late_cancel,
    input logic pipe_stall,
    input logic undef_trap,
    input logic instr_done
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert ({cp_pass, cp_late_cancel, pipe_stall, undef_trap, instr_done} == 5'b0); // R1
        end
    end

    AST_STALL_WITH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_stall |-> cp_pass); // R4

    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_trap |=> !undef_trap); // R3

    AST_IRQ_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_stall && irq_req) |=> (!cp_pass && !pipe_stall && !undef_trap && !instr_done)); // R7

    AST_CANCEL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        cp_late_cancel |-> ($past(cp_pass) && $past(prior_abort))); // R8

    AST_CANCEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_late_cancel |=> !cp_late_cancel); // R8

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cp_late_cancel, undef_trap, instr_done})); // R6

    AST_PULSE_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_late_cancel || undef_trap || instr_done) |-> (!cp_pass && !pipe_stall)); // R9

endmodule

bind cop_hs_seq cop_hs_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_req        (irq_req),
    .prior_abort    (prior_abort),
    .cp_pass        (cp_pass),
    .cp_late_cancel (cp_late_cancel),
    .pipe_stall     (pipe_stall),
    .undef_trap     (undef_trap),
    .instr_done     (instr_done)
);

// File: tb/cop_hs_seq_tb.sv
module cop_hs_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] C_WAIT = 2'b00, C_GO = 2'b01, C_ABSENT = 2'b10, C_LAST = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_vld = 1'b0, cond_pass = 1'b0, irq_req = 1'b0, prior_abort = 1'b0;
    logic [1:0] hs_dec = C_WAIT, hs_exe = C_WAIT;
    logic       cp_pass, cp_late_cancel, pipe_stall, undef_trap, instr_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    cop_hs_seq u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_vld      (issue_vld),
        .cond_pass      (cond_pass),
        .irq_req        (irq_req),
        .prior_abort    (prior_abort),
        .hs_dec         (hs_dec),
        .hs_exe         (hs_exe),
        .cp_pass        (cp_pass),
        .cp_late_cancel (cp_late_cancel),
        .pipe_stall     (pipe_stall),
        .undef_trap     (undef_trap),
        .instr_done     (instr_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        finish_run();
    end

    // Expected value order: {pass, late_cancel, stall, trap, done}
    task automatic expect_out(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {cp_pass, cp_late_cancel, pipe_stall, undef_trap, instr_done};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic drive(input logic iv, input logic cp, input logic ir, input logic ab,
                         input logic [1:0] hd, input logic [1:0] he);
        issue_vld   = iv;
        cond_pass   = cp;
        irq_req     = ir;
        prior_abort = ab;
        hs_dec      = hd;
        hs_exe      = he;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_step();
        drive(0, 0, 0, 0, C_WAIT, C_WAIT);
        tick();
    endtask

    task automatic t_reset();
        expect_out("R1 in reset", 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        expect_out("R1 after reset", 5'b00000);
    endtask

    task automatic t_last();
        drive(1, 1, 0, 0, C_LAST, C_WAIT); tick();
        expect_out("R6 last exec cycle", 5'b10000);
        idle_step();
        expect_out("R6 done pulse", 5'b00001);
        idle_step();
        expect_out("R6 back idle", 5'b00000);
    endtask

    task automatic t_absent();
        drive(1, 1, 0, 0, C_ABSENT, C_WAIT); tick();
        expect_out("R3 absent on issue", 5'b00010);
        idle_step();
        expect_out("R3 trap one cycle", 5'b00000);
    endtask

    task automatic t_wait_go_last();
        drive(1, 1, 0, 0, C_WAIT, C_WAIT); tick();
        expect_out("R4 busy entry", 5'b10100);
        // issue and a bad decode reply while busy: both ignored
        drive(1, 1, 0, 0, C_ABSENT, C_WAIT); tick();
        expect_out("R10 R2 busy holds", 5'b10100);
        drive(0, 0, 0, 0, C_WAIT, C_GO); tick();
        expect_out("R5 go cycle", 5'b10000);
        drive(0, 0, 0, 0, C_WAIT, C_GO); tick();
        expect_out("R5 second go", 5'b10000);
        drive(0, 0, 0, 0, C_WAIT, C_LAST); tick();
        expect_out("R6 last after go", 5'b10000);
        idle_step();
        expect_out("R6 done after go", 5'b00001);
        idle_step();
    endtask

    task automatic t_wait_absent();
        drive(1, 1, 0, 0, C_WAIT, C_WAIT); tick();
        expect_out("R4 busy", 5'b10100);
        drive(0, 0, 0, 0, C_WAIT, C_ABSENT); tick();
        expect_out("R3 absent in wait", 5'b00010);
        idle_step();
    endtask

    task automatic t_irq();
        drive(1, 1, 0, 0, C_WAIT, C_WAIT); tick();
        drive(0, 0, 0, 0, C_WAIT, C_WAIT); tick();
        expect_out("R4 still busy", 5'b10100);
        drive(0, 0, 1, 0, C_WAIT, C_WAIT); tick();
        expect_out("R7 irq drops pass", 5'b00000);
        idle_step();
        expect_out("R7 no trap or done", 5'b00000);
    endtask

    task automatic t_cancel();
        drive(1, 1, 0, 0, C_GO, C_WAIT); tick();
        expect_out("R5 first go", 5'b10000);
        drive(0, 0, 0, 1, C_WAIT, C_GO); tick();
        expect_out("R8 late cancel", 5'b01000);
        idle_step();
        expect_out("R8 no done", 5'b00000);
    endtask

    task automatic t_abort_late_ignored();
        drive(1, 1, 0, 0, C_WAIT, C_WAIT); tick();
        drive(0, 0, 0, 0, C_WAIT, C_WAIT); tick();
        drive(0, 0, 0, 1, C_WAIT, C_WAIT); tick();
        expect_out("R8 abort outside slot", 5'b10100);
        drive(0, 0, 0, 0, C_WAIT, C_LAST); tick();
        expect_out("R8 last", 5'b10000);
        idle_step();
        expect_out("R8 completes", 5'b00001);
        idle_step();
    endtask

    task automatic t_cond_fail();
        drive(1, 0, 0, 0, C_ABSENT, C_ABSENT); tick();
        expect_out("R9 retire", 5'b00001);
        idle_step();
        expect_out("R9 idle", 5'b00000);
    endtask

    task automatic t_fall_edge();
        drive(1, 1, 0, 0, C_LAST, C_WAIT);
        @(negedge clk);
        #2;
        hs_dec = C_ABSENT;
        tick();
        expect_out("R2 falling edge capture", 5'b10000);
        idle_step();
        expect_out("R2 done", 5'b00001);
        idle_step();
    endtask

    initial begin
        #2;
        t_reset();
        t_last();
        t_absent();
        t_wait_go_last();
        t_wait_absent();
        t_irq();
        t_cancel();
        t_abort_late_ignored();
        t_cond_fail();
        t_fall_edge();
        finish_run();
    end

endmodule